// File: doc/BRIEF.md
# Two-Antenna Preamble Diversity Selector

This block picks one of two receive antennas while a packet preamble is arriving, with no processor in the loop. Once the search is armed (diversity enabled and the receiver active), it listens on the current antenna for one dwell window. During that window it compares every valid correlator sample against a programmable threshold. If no sample beats the threshold by the end of the window, it flips the antenna and waits through a short settling gap. It then listens on the other antenna. The first antenna to produce a sample above the threshold is frozen for the rest of the packet.

With the default 32 MHz timing, a dwell is 512 cycles (one 16 µs symbol) and a gap is 256 cycles (8 µs). Both antennas are therefore tried well inside the first four preamble symbols. The lock is released by the end-of-packet pulse or by the receiver dropping. The next search then begins on the antenna that was last in use. With diversity disabled, the antenna follows a direct select input.

The controller has four states:
- `FAD_IDLE`: not searching.
- `FAD_DWELL`: listening on one antenna.
- `FAD_GAP`: the switch is settling after a flip.
- `FAD_LOCK`: an antenna has been chosen.

The transitions are:
- IDLE→DWELL when enabled, receiving and no end-of-packet.
- DWELL→LOCK on a qualifying sample.
- DWELL→GAP when the dwell window expires, flipping the antenna.
- GAP→DWELL when the gap expires.
- LOCK→IDLE on end-of-packet.
- Any state→IDLE when diversity is disabled or the receiver goes inactive.

Top module: `ant_div_ctrl`

## Requirements
- R1: After reset, `ant_a`=1, `ant_b`=0 (antenna A, select value 0), `lock_valid`=0 and `sw_gap`=0.
- R2: While `fad_en`=0, the antenna follows `manual_sel` one clock later (0 selects A, 1 selects B), and correlator samples cause no lock.
- R3: Once `fad_en` and `rx_active` are high, the controller listens on the current antenna for exactly DWELL_CYC clocks before switching.
- R4: Each switch is followed by GAP_CYC clocks with `sw_gap`=1 and the new antenna already driven; samples arriving during the gap are ignored.
- R5: A sample with `corr_valid`=1 and `corr_val` strictly greater than `corr_thr` during a dwell sets `lock_valid`=1 at the next clock, with `lock_ant` equal to the antenna that was listening. A sample equal to the threshold, or one without `corr_valid`, does not qualify.
- R6: If no antenna qualifies, the controller keeps alternating dwell, gap, dwell on the other antenna, without end.
- R7: The lock and the chosen antenna hold until `eop` or `rx_active`=0. Either one clears `lock_valid` at the next clock, and the next search starts on the antenna last in use.
- R8: Dropping `fad_en` in the middle of a search returns to idle at the next clock and hands the antenna to `manual_sel`.
- R9: `ant_a` and `ant_b` are always complementary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (32 MHz for the default timing) |
| rst_n | input | 1 | Active-low asynchronous reset |
| fad_en | input | 1 | Enables the automatic antenna search |
| rx_active | input | 1 | Receiver is on |
| eop | input | 1 | End-of-packet pulse, releases the lock |
| manual_sel | input | 1 | Direct antenna choice used while the search is disabled |
| corr_valid | input | 1 | Correlator sample strobe |
| corr_val | input | CORR_W | Correlator metric |
| corr_thr | input | CORR_W | Qualification threshold |
| ant_a | output | 1 | Drive for antenna A switch |
| ant_b | output | 1 | Drive for antenna B switch |
| sw_gap | output | 1 | High while the switch is settling |
| lock_valid | output | 1 | An antenna is locked for this packet |
| lock_ant | output | 1 | Last locked antenna (0 = A, 1 = B) |

## Verification
The hardest situation to reach is a lock on antenna B that arises from the search itself rather than from the direct select. A lock on B needs a full unqualified dwell on A, a full gap, and then a qualifying sample placed inside the B dwell. That lock must then be released so that the restart can be seen to begin on B. The bench gets there with counted clock steps from a known entry edge. It holds a strong sample active across the whole gap to prove the gap ignores it. Only after reaching the B dwell does it present the qualifying sample. It then drops `rx_active`, raises it again, and times the following dwell.

// File: rtl/ant_div_pkg.sv
package ant_div_pkg;

    typedef enum logic [1:0] {
        FAD_IDLE  = 2'd0,
        FAD_DWELL = 2'd1,
        FAD_GAP   = 2'd2,
        FAD_LOCK  = 2'd3
    } fad_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ant_div_timer.sv
module ant_div_timer #(
    parameter int unsigned DWELL_CYC = 512,
    parameter int unsigned GAP_CYC   = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic gap_phase,
    output logic expire
);
    import ant_div_pkg::*;

    localparam int unsigned LONGEST = max_u(DWELL_CYC, GAP_CYC);
    localparam int unsigned CW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [CW-1:0] DWELL_LAST = CW'(DWELL_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        expire = gap_phase ? (cnt_q == GAP_LAST) : (cnt_q == DWELL_LAST);
    end

endmodule

// File: rtl/ant_div_qual.sv
module ant_div_qual #(
    parameter int unsigned CORR_W = 8
) (
    input  logic              window_open,
    input  logic              corr_valid,
    input  logic [CORR_W-1:0] corr_val,
    input  logic [CORR_W-1:0] corr_thr,
    output logic              hit
);
    always_comb begin
        hit = window_open && corr_valid && (corr_val > corr_thr);
    end
endmodule

// File: rtl/ant_div_fsm.sv
module ant_div_fsm
    import ant_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fad_en,
    input  logic rx_active,
    input  logic eop,
    input  logic manual_sel,
    input  logic hit,
    input  logic expire,
    output logic restart,
    output logic in_dwell,
    output logic in_gap,
    output logic ant_a,
    output logic ant_b,
    output logic sw_gap,
    output logic lock_valid,
    output logic lock_ant
);
    fad_state_e state_q, state_d;
    logic       cur_ant_q;
    logic       lock_ant_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!fad_en || !rx_active) begin
            state_d = FAD_IDLE;
        end else begin
            unique case (state_q)
                FAD_IDLE:  if (!eop) state_d = FAD_DWELL;
                FAD_DWELL: begin
                    if (hit)         state_d = FAD_LOCK;
                    else if (expire) state_d = FAD_GAP;
                end
                FAD_GAP:   if (expire) state_d = FAD_DWELL;
                FAD_LOCK:  if (eop)    state_d = FAD_IDLE;
            endcase
        end
    end

    // state and antenna registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= FAD_IDLE;
            cur_ant_q  <= 1'b0;
            lock_ant_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!fad_en)
                cur_ant_q <= manual_sel;
            else if (state_q == FAD_DWELL && state_d == FAD_GAP)
                cur_ant_q <= ~cur_ant_q;
            if (state_q == FAD_DWELL && state_d == FAD_LOCK)
                lock_ant_q <= cur_ant_q;
        end
    end

    // outputs
    always_comb begin
        restart    = (state_d != state_q);
        in_dwell   = (state_q == FAD_DWELL);
        in_gap     = (state_q == FAD_GAP);
        ant_a      = ~cur_ant_q;
        ant_b      = cur_ant_q;
        sw_gap     = (state_q == FAD_GAP);
        lock_valid = (state_q == FAD_LOCK);
        lock_ant   = lock_ant_q;
    end

endmodule

// File: rtl/ant_div_ctrl.sv
module ant_div_ctrl #(
    parameter int unsigned CORR_W    = 8,
    parameter int unsigned DWELL_CYC = 512,
    parameter int unsigned GAP_CYC   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fad_en,
    input  logic              rx_active,
    input  logic              eop,
    input  logic              manual_sel,
    input  logic              corr_valid,
    input  logic [CORR_W-1:0] corr_val,
    input  logic [CORR_W-1:0] corr_thr,
    output logic              ant_a,
    output logic              ant_b,
    output logic              sw_gap,
    output logic              lock_valid,
    output logic              lock_ant
);
    logic hit, expire, restart, in_dwell, in_gap;

    ant_div_qual #(.CORR_W(CORR_W)) u_qual (
        .window_open (in_dwell),
        .corr_valid  (corr_valid),
        .corr_val    (corr_val),
        .corr_thr    (corr_thr),
        .hit         (hit)
    );

    ant_div_timer #(.DWELL_CYC(DWELL_CYC), .GAP_CYC(GAP_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .gap_phase (in_gap),
        .expire    (expire)
    );

    ant_div_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fad_en     (fad_en),
        .rx_active  (rx_active),
        .eop        (eop),
        .manual_sel (manual_sel),
        .hit        (hit),
        .expire     (expire),
        .restart    (restart),
        .in_dwell   (in_dwell),
        .in_gap     (in_gap),
        .ant_a      (ant_a),
        .ant_b      (ant_b),
        .sw_gap     (sw_gap),
        .lock_valid (lock_valid),
        .lock_ant   (lock_ant)
    );

endmodule

// File: rtl/ant_div_chk.sv
module ant_div_chk #(
    parameter int unsigned CORR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fad_en,
    input logic              rx_active,
    input logic              eop,
    input logic              corr_valid,
    input logic [CORR_W-1:0] corr_val,
    input logic [CORR_W-1:0] corr_thr,
    input logic              ant_b,
    input logic              sw_gap,
    input logic              lock_valid,
    input logic              lock_ant
);
    // R2
    no_lock_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fad_en |=> (!lock_valid && !sw_gap));

    // R4
    gap_never_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_gap |=> !lock_valid);

    // R5
    lock_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_valid) |-> ($past(corr_valid) && ($past(corr_val) > $past(corr_thr))
                               && (lock_ant == $past(ant_b))));

    // R7
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_valid && fad_en && rx_active && !eop) |=> (lock_valid && $stable(lock_ant) && $stable(ant_b)));

    // R7
    eop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_valid && eop) |=> !lock_valid);

    // R3
    switch_only_into_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fad_en) && (ant_b != $past(ant_b))) |-> sw_gap);

endmodule

bind ant_div_ctrl ant_div_chk #(.CORR_W(CORR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fad_en     (fad_en),
    .rx_active  (rx_active),
    .eop        (eop),
    .corr_valid (corr_valid),
    .corr_val   (corr_val),
    .corr_thr   (corr_thr),
    .ant_b      (ant_b),
    .sw_gap     (sw_gap),
    .lock_valid (lock_valid),
    .lock_ant   (lock_ant)
);

// File: tb/ant_div_ctrl_bench.sv
`timescale 1ns/1ps
module ant_div_ctrl_bench;
    localparam int unsigned CW    = 8;
    localparam int unsigned DWELL = 512;
    localparam int unsigned GAP   = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fad_en = 1'b0, rx_active = 1'b0, eop = 1'b0, manual_sel = 1'b0;
    logic corr_valid = 1'b0;
    logic [CW-1:0] corr_val = '0, corr_thr = '0;
    logic ant_a, ant_b, sw_gap, lock_valid, lock_ant;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ant_div_ctrl #(.CORR_W(CW), .DWELL_CYC(DWELL), .GAP_CYC(GAP)) u_ant_div_ctrl (
        .clk(clk), .rst_n(rst_n), .fad_en(fad_en), .rx_active(rx_active), .eop(eop),
        .manual_sel(manual_sel), .corr_valid(corr_valid), .corr_val(corr_val),
        .corr_thr(corr_thr), .ant_a(ant_a), .ant_b(ant_b), .sw_gap(sw_gap),
        .lock_valid(lock_valid), .lock_ant(lock_ant)
    );

    // vector: [18] antenna, [17] valid, [16:9] value, [8:1] threshold, [0] expect lock
    localparam logic [18:0] VEC [8] = '{
        {1'b0, 1'b1, 8'd100, 8'd50,  1'b1},
        {1'b1, 1'b1, 8'd100, 8'd50,  1'b1},
        {1'b0, 1'b1, 8'd50,  8'd50,  1'b0},
        {1'b1, 1'b1, 8'd49,  8'd50,  1'b0},
        {1'b0, 1'b0, 8'd200, 8'd50,  1'b0},
        {1'b1, 1'b1, 8'd255, 8'd254, 1'b1},
        {1'b0, 1'b1, 8'd1,   8'd0,   1'b1},
        {1'b1, 1'b1, 8'd0,   8'd0,   1'b0}
    };

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 ant_a", ant_a, 1); chk("R1 ant_b", ant_b, 0);
        chk("R1 lock", lock_valid, 0); chk("R1 gap", sw_gap, 0);
        rst_n = 1'b1;
        tick(1);
        chk("R9 compl", ant_a ^ ant_b, 1);

        // table walk: R5 qualification rule
        for (int i = 0; i < 8; i++) begin
            fad_en = 0; rx_active = 0; manual_sel = VEC[i][18];
            tick(1);
            chk("R2 manual", ant_b, VEC[i][18]);
            fad_en = 1; rx_active = 1;
            tick(1);
            corr_valid = VEC[i][17]; corr_val = VEC[i][16:9]; corr_thr = VEC[i][8:1];
            tick(1);
            corr_valid = 0;
            chk("R5 lock", lock_valid, VEC[i][0]);
            if (VEC[i][0]) chk("R5 lock_ant", lock_ant, VEC[i][18]);
            chk("R9 compl", ant_a ^ ant_b, 1);
            rx_active = 0;
            tick(1);
            chk("R7 rx drop", lock_valid, 0);
        end

        // R2: search disabled ignores samples
        fad_en = 0; rx_active = 1; manual_sel = 1;
        corr_valid = 1; corr_val = 200; corr_thr = 10;
        tick(4);
        chk("R2 no lock", lock_valid, 0); chk("R2 sel B", ant_b, 1); chk("R2 ant_a", ant_a, 0);
        corr_valid = 0;

        // R3 dwell length on A
        manual_sel = 0; tick(1);
        fad_en = 1; tick(1);
        tick(DWELL - 1);
        chk("R3 last dwell ant", ant_b, 0); chk("R3 last dwell gap", sw_gap, 0);
        tick(1);
        chk("R3 switched", ant_b, 1); chk("R4 gap on", sw_gap, 1);
        // R4 gap ignores strong samples
        corr_valid = 1; corr_val = 250; corr_thr = 5;
        tick(GAP - 1);
        chk("R4 gap last", sw_gap, 1); chk("R4 ignored", lock_valid, 0);
        corr_valid = 0;
        tick(1);
        chk("R4 gap end", sw_gap, 0); chk("R4 on B", ant_b, 1); chk("R4 no lock", lock_valid, 0);
        // R6 alternation back to A
        tick(DWELL);
        chk("R6 back to A", ant_b, 0); chk("R6 gap", sw_gap, 1);
        tick(GAP);
        chk("R6 dwell A", sw_gap, 0);
        corr_valid = 1; corr_val = 90; corr_thr = 80;
        tick(1);
        corr_valid = 0;
        chk("R5 lock A", lock_valid, 1); chk("R5 lock_ant A", lock_ant, 0);
        // R7 hold
        corr_valid = 1; corr_val = 0; corr_thr = 255;
        tick(2000);
        corr_valid = 0;
        chk("R7 hold", lock_valid, 1); chk("R7 hold ant", ant_b, 0); chk("R7 no gap", sw_gap, 0);
        eop = 1; tick(1); eop = 0;
        chk("R7 eop release", lock_valid, 0);
        // restart on A, search to B and lock there
        tick(1);
        tick(DWELL);
        chk("R6 to B", ant_b, 1);
        tick(GAP);
        corr_valid = 1; corr_val = 30; corr_thr = 20;
        tick(1);
        corr_valid = 0;
        chk("R5 lock B", lock_valid, 1); chk("R5 lock_ant B", lock_ant, 1);
        rx_active = 0; tick(1);
        chk("R7 release", lock_valid, 0); chk("R7 keep B", ant_b, 1);
        rx_active = 1; tick(1);
        chk("R7 restart B", ant_b, 1); chk("R7 restart dwell", sw_gap, 0);
        tick(DWELL - 1);
        chk("R7 B dwell len", ant_b, 1);
        tick(1);
        chk("R7 then A", ant_b, 0); chk("R7 gap", sw_gap, 1);

        // R8 abort during gap
        fad_en = 0; manual_sel = 1; tick(1);
        chk("R8 abort gap", sw_gap, 0); chk("R8 manual", ant_b, 1); chk("R8 no lock", lock_valid, 0);
        // R8 abort during dwell
        fad_en = 1; tick(5);
        fad_en = 0; manual_sel = 0; tick(1);
        chk("R8 abort dwell", ant_b, 0); chk("R9 compl", ant_a, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule